// File: doc/BRIEF.md
# Block Transfer Controller Between Sample FIFOs and Word Memory

This controller moves 16-bit sample words in fixed-size blocks. A capture FIFO feeds it, it stores the blocks in a word-addressed external memory, and later it plays them back into a readback FIFO. It has two modes. In capture mode, each time the capture FIFO holds a whole block, the controller copies that block into memory at the block named by its write pointer. It stops accepting blocks once one more block would push the count of stored samples past a host-programmed limit. When the host issues a read command, the controller enters readback mode and stays there until reset. In readback mode it copies one block from memory into the readback FIFO whenever that FIFO has space for a whole block. It uses its own read pointer for this, and it stops when the read pointer meets the write pointer.

The memory port has a single request/ready handshake. A word moves on every cycle where `mem_req` and `mem_rdy` are both high. For a write, the memory takes `mem_wdata` on that cycle. For a read, the memory drives `mem_rdata` on that cycle. The capture FIFO is first-word-fall-through: `in_dout` shows the oldest word and `in_rd_en` pops it. Both FIFOs report their fill level as a word count. A 24-bit status word gives the host the mode and the write pointer.

States: `ST_CAP_WAIT` (capture, idle), `ST_CAP_MOVE` (capture, block in flight), `ST_RDB_WAIT` (readback, idle), `ST_RDB_MOVE` (readback, block in flight). Transitions:
- capture start: `ST_CAP_WAIT`→`ST_CAP_MOVE`
- capture finish: `ST_CAP_MOVE`→`ST_CAP_WAIT`
- mode switch: `ST_CAP_WAIT`→`ST_RDB_WAIT`
- readback start: `ST_RDB_WAIT`→`ST_RDB_MOVE`
- readback finish: `ST_RDB_MOVE`→`ST_RDB_WAIT`

Top module: `blkxfer_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in capture mode with both pointers and the sample count at zero. After reset, `status` is 24'h00000A and `mem_req`, `in_rd_en` and `out_wr_en` are low.
- R2: A capture block starts only when `in_rd_count` is at least BLK_WORDS. While fewer words are present, `mem_req` stays low and no word is popped.
- R3: During a capture block, `mem_we` is 1 and `mem_wdata` equals `in_dout`. `in_rd_en` is high exactly on cycles where `mem_req` and `mem_rdy` are both high. Beat k of a block goes to address write_block*BLK_WORDS+k. The block ends after BLK_WORDS accepted beats.
- R4: The write pointer is a block index. It advances by one at the end of each capture block and wraps from MEM_BLKS-1 to 0. `status[23:8]` holds the write block index, zero-extended.
- R5: A capture block starts only if the samples already written plus BLK_WORDS does not exceed `cap_limit`. Blocks that fail this test stay in the capture FIFO.
- R6: A one-cycle pulse on `rd_cmd` in capture mode moves the block to readback mode. If a block is in flight, that block completes first. `status[7:0]` is 8'h0A in capture mode and 8'h0B in readback mode.
- R7: A readback block starts only when FIFO_BLKS*BLK_WORDS minus `out_wr_count` is at least BLK_WORDS.
- R8: During a readback block, `mem_we` is 0 and `out_din` equals `mem_rdata`. `out_wr_en` is high exactly on cycles where `mem_req` and `mem_rdy` are both high. Beat k reads address read_block*BLK_WORDS+k. The read pointer starts at 0 and advances per block in the same way as the write pointer.
- R9: No readback block starts while the read block index equals the write block index.
- R10: Readback mode persists until reset. In readback mode, `rd_cmd` has no effect and `in_rd_en` stays low whatever the capture FIFO holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_cmd | input | 1 | Host command to enter readback mode |
| cap_limit | input | SCNT_W | Maximum number of samples to store |
| in_rd_count | input | FCNT_W | Words present in the capture FIFO |
| in_dout | input | WORD_W | Head word of the capture FIFO |
| in_rd_en | output | 1 | Pop strobe to the capture FIFO |
| out_wr_count | input | FCNT_W | Words present in the readback FIFO |
| out_din | output | WORD_W | Word pushed into the readback FIFO |
| out_wr_en | output | 1 | Push strobe to the readback FIFO |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data, valid when `mem_rdy` is high |
| mem_rdy | input | 1 | Memory accepts or returns a word this cycle |
| status | output | 24 | {write block index[15:0], mode code[7:0]} |

## Verification
The hardest case to produce is a read command that arrives while a capture block is only partly transferred. The block must finish in full, and only then may the mode change. To reach this case, the bench slows the memory so that it is ready on only two cycles in three. It then pulses `rd_cmd` one cycle after the block's first request, while the readback FIFO is kept nearly full so that no readback starts. Finally it checks that the whole block is in memory and that the status shows readback mode with the advanced write pointer. A second case that needs set-up is the limit test: the sample limit is chosen so that exactly one queued block is refused.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        ST_CAP_WAIT,
        ST_CAP_MOVE,
        ST_RDB_WAIT,
        ST_RDB_MOVE
    } xfer_state_t;

    localparam logic [7:0] MODE_CODE_CAP = 8'h0A;
    localparam logic [7:0] MODE_CODE_RDB = 8'h0B;
    localparam int         STATUS_W      = 24;
    localparam int         STATUS_PTR_W  = 16;

endpackage

// File: rtl/blkxfer_ptr.sv
module blkxfer_ptr #(
    parameter int NBLK = 4,
    localparam int IW  = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [IW-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            if (idx == IW'(NBLK - 1)) begin
                idx <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R4: the pointer only moves on a block completion
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx));

    // R4: the pointer never leaves the configured memory
    p_range_r4: assert property (@(posedge clk) disable iff (rst)
        int'(idx) < NBLK);

endmodule

// File: rtl/blkxfer_status.sv
module blkxfer_status #(
    parameter int BIDX_W = 2
) (
    input  logic              rd_mode,
    input  logic [BIDX_W-1:0] wr_blk,
    output logic [23:0]       status
);
    import blkxfer_pkg::*;

    logic [STATUS_PTR_W-1:0] ptr_field;

    generate
        if (BIDX_W >= STATUS_PTR_W) begin : g_trunc
            assign ptr_field = wr_blk[STATUS_PTR_W-1:0];
        end else begin : g_ext
            assign ptr_field = {{(STATUS_PTR_W - BIDX_W){1'b0}}, wr_blk};
        end
    endgenerate

    assign status = {ptr_field, rd_mode ? MODE_CODE_RDB : MODE_CODE_CAP};

endmodule

// File: rtl/blkxfer_fsm.sv
module blkxfer_fsm #(
    parameter int BLK_WORDS  = 512,
    parameter int FIFO_WORDS = 2048,
    parameter int SCNT_W     = 32,
    parameter int FCNT_W     = 12,
    parameter int BEAT_W     = 9,
    parameter int BIDX_W     = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cmd,
    input  logic [SCNT_W-1:0] cap_limit,
    input  logic [FCNT_W-1:0] in_rd_count,
    input  logic [FCNT_W-1:0] out_wr_count,
    input  logic              mem_rdy,
    input  logic [BIDX_W-1:0] wr_blk,
    input  logic [BIDX_W-1:0] rd_blk,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BIDX_W+BEAT_W-1:0] mem_addr,
    output logic              in_rd_en,
    output logic              out_wr_en,
    output logic              cap_step,
    output logic              rdb_step,
    output logic              rd_mode
);
    import blkxfer_pkg::*;

    xfer_state_t       state;
    xfer_state_t       nxt;
    logic [BEAT_W-1:0] beat;
    logic [SCNT_W-1:0] smp_cnt;
    logic              switch_pend;

    logic cap_full_blk;
    logic cap_budget;
    logic rdb_room;
    logic rdb_data;
    logic last_beat;
    logic beat_ok;
    logic [FCNT_W-1:0] rdb_free;

    assign cap_full_blk = in_rd_count >= FCNT_W'(BLK_WORDS);
    assign cap_budget   = ({1'b0, smp_cnt} + (SCNT_W+1)'(BLK_WORDS)) <= {1'b0, cap_limit};
    assign rdb_free     = FCNT_W'(FIFO_WORDS) - out_wr_count;
    assign rdb_room     = rdb_free >= FCNT_W'(BLK_WORDS);
    assign rdb_data     = rd_blk != wr_blk;
    assign last_beat    = beat == BEAT_W'(BLK_WORDS - 1);
    assign beat_ok      = mem_req && mem_rdy;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CAP_WAIT;
        end else begin
            state <= nxt;
        end
    end

    // beat, sample count and deferred mode switch
    always_ff @(posedge clk) begin
        if (rst) begin
            beat        <= '0;
            smp_cnt     <= '0;
            switch_pend <= 1'b0;
        end else begin
            if (beat_ok) begin
                beat <= last_beat ? '0 : beat + 1'b1;
            end
            if (state == ST_CAP_MOVE && mem_rdy) begin
                smp_cnt <= smp_cnt + 1'b1;
            end
            if (state == ST_CAP_MOVE && rd_cmd) begin
                switch_pend <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CAP_WAIT: begin
                if (rd_cmd || switch_pend) begin
                    nxt = ST_RDB_WAIT;
                end else if (cap_full_blk && cap_budget) begin
                    nxt = ST_CAP_MOVE;
                end
            end
            ST_CAP_MOVE: begin
                if (mem_rdy && last_beat) begin
                    nxt = ST_CAP_WAIT;
                end
            end
            ST_RDB_WAIT: begin
                if (rdb_data && rdb_room) begin
                    nxt = ST_RDB_MOVE;
                end
            end
            ST_RDB_MOVE: begin
                if (mem_rdy && last_beat) begin
                    nxt = ST_RDB_WAIT;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {wr_blk, beat};
        in_rd_en  = 1'b0;
        out_wr_en = 1'b0;
        cap_step  = 1'b0;
        rdb_step  = 1'b0;
        rd_mode   = 1'b0;
        unique case (state)
            ST_CAP_WAIT: begin
                rd_mode = 1'b0;
            end
            ST_CAP_MOVE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                in_rd_en = mem_rdy;
                cap_step = mem_rdy && last_beat;
            end
            ST_RDB_WAIT: begin
                rd_mode  = 1'b1;
                mem_addr = {rd_blk, beat};
            end
            ST_RDB_MOVE: begin
                rd_mode   = 1'b1;
                mem_req   = 1'b1;
                mem_addr  = {rd_blk, beat};
                out_wr_en = mem_rdy;
                rdb_step  = mem_rdy && last_beat;
            end
        endcase
    end

    // R2: a capture block begins only after a whole block was present
    p_cap_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAP_MOVE && $past(state) == ST_CAP_WAIT) |-> $past(cap_full_blk));

    // R5: a capture block begins only within the sample budget
    p_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAP_MOVE && $past(state) == ST_CAP_WAIT) |-> $past(cap_budget));

    // R3: a pop happens only with an accepted memory write
    p_pop_hs_r3: assert property (@(posedge clk) disable iff (rst)
        in_rd_en |-> (mem_req && mem_we && mem_rdy));

    // R3: a stalled beat keeps its position
    p_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> $stable(beat));

    // R8: a push happens only with a returned memory word
    p_push_hs_r8: assert property (@(posedge clk) disable iff (rst)
        out_wr_en |-> (mem_req && !mem_we && mem_rdy));

    // R7: a readback block begins only with room for a whole block
    p_room_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDB_MOVE && $past(state) == ST_RDB_WAIT) |-> $past(rdb_room));

    // R9: a readback block begins only while pointers differ
    p_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDB_MOVE && $past(state) == ST_RDB_WAIT) |-> $past(rd_blk != wr_blk));

    // R10: readback mode is kept until reset
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        rd_mode |=> rd_mode);

    // R10: the capture FIFO is never popped in readback mode
    p_no_pop_r10: assert property (@(posedge clk) disable iff (rst)
        rd_mode |-> !in_rd_en);

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl #(
    parameter int WORD_W     = 16,
    parameter int BLK_WORDS  = 512,
    parameter int FIFO_BLKS  = 4,
    parameter int MEM_BLKS   = 32768,
    parameter int SCNT_W     = 32,
    localparam int BEAT_W     = $clog2(BLK_WORDS),
    localparam int BIDX_W     = $clog2(MEM_BLKS),
    localparam int ADDR_W     = BIDX_W + BEAT_W,
    localparam int FIFO_WORDS = FIFO_BLKS * BLK_WORDS,
    localparam int FCNT_W     = $clog2(FIFO_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cmd,
    input  logic [SCNT_W-1:0] cap_limit,
    input  logic [FCNT_W-1:0] in_rd_count,
    input  logic [WORD_W-1:0] in_dout,
    output logic              in_rd_en,
    input  logic [FCNT_W-1:0] out_wr_count,
    output logic [WORD_W-1:0] out_din,
    output logic              out_wr_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic [23:0]       status
);

    logic [BIDX_W-1:0] wr_blk;
    logic [BIDX_W-1:0] rd_blk;
    logic              cap_step;
    logic              rdb_step;
    logic              rd_mode;

    assign mem_wdata = in_dout;
    assign out_din   = mem_rdata;

    blkxfer_fsm #(
        .BLK_WORDS (BLK_WORDS),
        .FIFO_WORDS(FIFO_WORDS),
        .SCNT_W    (SCNT_W),
        .FCNT_W    (FCNT_W),
        .BEAT_W    (BEAT_W),
        .BIDX_W    (BIDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .rd_cmd      (rd_cmd),
        .cap_limit   (cap_limit),
        .in_rd_count (in_rd_count),
        .out_wr_count(out_wr_count),
        .mem_rdy     (mem_rdy),
        .wr_blk      (wr_blk),
        .rd_blk      (rd_blk),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .in_rd_en    (in_rd_en),
        .out_wr_en   (out_wr_en),
        .cap_step    (cap_step),
        .rdb_step    (rdb_step),
        .rd_mode     (rd_mode)
    );

    blkxfer_ptr #(.NBLK(MEM_BLKS)) u_wr_ptr (
        .clk (clk),
        .rst (rst),
        .step(cap_step),
        .idx (wr_blk)
    );

    blkxfer_ptr #(.NBLK(MEM_BLKS)) u_rd_ptr (
        .clk (clk),
        .rst (rst),
        .step(rdb_step),
        .idx (rd_blk)
    );

    blkxfer_status #(.BIDX_W(BIDX_W)) u_status (
        .rd_mode(rd_mode),
        .wr_blk (wr_blk),
        .status (status)
    );

    // R6: the write pointer is frozen in readback mode
    p_wr_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        rd_mode |=> $stable(wr_blk));

    // R8: the read pointer is frozen in capture mode
    p_rd_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_mode |=> $stable(rd_blk));

endmodule

// File: tb/blkxfer_ctrl_bench.sv
`timescale 1ns/1ps
module blkxfer_ctrl_bench;

    localparam int BLK  = 4;
    localparam int FBLK = 4;
    localparam int MBLK = 4;
    localparam int FW   = 5;
    localparam int AW   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_cmd = 1'b0;
    logic [31:0] cap_limit = 32'd22;
    logic [FW-1:0] in_rd_count;
    logic [15:0] in_dout;
    logic        in_rd_en;
    logic [FW-1:0] out_wr_count;
    logic [15:0] out_din;
    logic        out_wr_en;
    logic        mem_req;
    logic        mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rdy;
    logic [23:0] status;

    int total = 0;
    int bad   = 0;
    int hs_bad = 0;

    logic [15:0] in_q [0:255];
    int in_pushed = 0;
    int in_popped = 0;
    logic [15:0] mem [0:15];
    logic [15:0] out_q [0:63];
    int out_pushed = 0;
    int out_pre = 0;
    int out_drained = 0;
    int rdy_mode = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    assign in_rd_count  = FW'(in_pushed - in_popped);
    assign in_dout      = in_q[in_popped[7:0]];
    assign out_wr_count = FW'(out_pre + out_pushed - out_drained);
    assign mem_rdata    = mem[mem_addr];
    assign mem_rdy      = (rdy_mode == 0) ? 1'b1 : ((cyc % rdy_mode) != 0);

    blkxfer_ctrl #(
        .WORD_W(16), .BLK_WORDS(BLK), .FIFO_BLKS(FBLK), .MEM_BLKS(MBLK), .SCNT_W(32)
    ) u_blkxfer_ctrl (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .cap_limit(cap_limit),
        .in_rd_count(in_rd_count), .in_dout(in_dout), .in_rd_en(in_rd_en),
        .out_wr_count(out_wr_count), .out_din(out_din), .out_wr_en(out_wr_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .status(status)
    );

    // models of the FIFOs and the memory
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (in_rd_en) in_popped <= in_popped + 1;
        if (mem_req && mem_rdy && mem_we) mem[mem_addr] <= mem_wdata;
        if (out_wr_en) begin
            out_q[out_pushed[5:0]] <= out_din;
            out_pushed <= out_pushed + 1;
        end
    end

    // R3 / R8 handshake monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (in_rd_en !== (mem_req && mem_we && mem_rdy)) hs_bad = hs_bad + 1;
            if (out_wr_en !== (mem_req && !mem_we && mem_rdy)) hs_bad = hs_bad + 1;
            if (mem_req && mem_we && mem_wdata !== in_dout) hs_bad = hs_bad + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push_blk(input logic [15:0] base);
        for (int i = 0; i < BLK; i++) begin
            in_q[in_pushed[7:0]] = base + 16'(i);
            in_pushed = in_pushed + 1;
        end
    endtask

    task automatic wait_cap_done();
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (!mem_req && in_rd_count < FW'(BLK)) break;
        end
    endtask

    task automatic idle_check(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mem_req) seen = seen + 1;
        end
        chk(seen == 0, tag, 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad = bad + 1;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 24'h00000A, "R1 reset status", 32'(status), 32'h0A);
        chk(!mem_req && !in_rd_en && !out_wr_en, "R1 idle strobes",
            {29'd0, mem_req, in_rd_en, out_wr_en}, 32'd0);

        // R2: partial block is left alone
        for (int i = 0; i < BLK - 1; i++) begin
            in_q[in_pushed[7:0]] = 16'h1000 + 16'(i);
            in_pushed = in_pushed + 1;
        end
        idle_check(10, "R2 partial block no request");
        chk(in_rd_count == 5'd3, "R2 partial block kept", 32'(in_rd_count), 32'd3);
        in_q[in_pushed[7:0]] = 16'h1003;
        in_pushed = in_pushed + 1;
        wait_cap_done();
        chk(status == 24'h00010A, "R4 first block pointer", 32'(status), 32'h00010A);

        // sweep further blocks with varied memory readiness, including wrap
        for (int b = 1; b < 5; b++) begin
            rdy_mode = b + 1;
            push_blk(16'h1000 + 16'(b * 16));
            wait_cap_done();
            chk(status[23:8] == 16'((b + 1) % MBLK), "R4 pointer step/wrap",
                32'(status[23:8]), 32'((b + 1) % MBLK));
            chk(in_rd_count == 5'd0, "R3 block fully drained", 32'(in_rd_count), 32'd0);
        end

        // R5: sixth block exceeds the limit of 22 samples
        push_blk(16'h1060);
        idle_check(20, "R5 limit blocks request");
        chk(in_rd_count == 5'd4, "R5 block left in fifo", 32'(in_rd_count), 32'd4);
        chk(status == 24'h00010A, "R5 pointer unchanged", 32'(status), 32'h00010A);

        // R3 / R4: memory image after the wrap
        for (int a = 0; a < 16; a++) begin
            logic [15:0] e;
            e = (a < BLK) ? 16'h1040 + 16'(a) : 16'h1000 + 16'((a / BLK) * 16 + (a % BLK));
            chk(mem[a] == e, "R3 memory word", 32'(mem[a]), 32'(e));
        end

        // phase B: reset, then readback
        rst = 1'b1;
        in_popped = in_pushed;
        cap_limit = 32'd100;
        rdy_mode = 0;
        out_pre = 13;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 24'h00000A, "R1 reset clears pointer", 32'(status), 32'h0A);
        push_blk(16'h2000);
        wait_cap_done();
        push_blk(16'h2010);
        wait_cap_done();
        rdy_mode = 3;
        push_blk(16'h2020);
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (mem_req) break;
        end
        @(negedge clk);
        rd_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0;
        chk(status[7:0] == 8'h0A, "R6 mode held mid-block", 32'(status[7:0]), 32'h0A);
        wait_cap_done();
        repeat (2) @(negedge clk);
        chk(status == 24'h00030B, "R6 switch after block", 32'(status), 32'h00030B);
        for (int i = 0; i < BLK; i++)
            chk(mem[8 + i] == 16'h2020 + 16'(i), "R6 deferred block complete",
                32'(mem[8 + i]), 32'(16'h2020 + 16'(i)));

        // R7: three free words is not enough
        idle_check(10, "R7 no room no readback");

        // R10: capture input and read command ignored in readback mode
        push_blk(16'h3000);
        rd_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0;
        repeat (10) @(negedge clk);
        chk(in_rd_count == 5'd4, "R10 no pop in readback", 32'(in_rd_count), 32'd4);
        chk(status == 24'h00030B, "R10 status unchanged", 32'(status), 32'h00030B);

        // R7: exactly one block of room
        out_pre = 12;
        repeat (30) @(negedge clk);
        chk(out_pushed == 4, "R7 one block read", 32'(out_pushed), 32'd4);
        chk(!mem_req, "R7 stalls when full", 32'(mem_req), 32'd0);

        // R9: drain and read remaining blocks, then stop at the write pointer
        out_drained = out_pushed;
        for (int n = 0; n < 6; n++) begin
            repeat (10) @(negedge clk);
            out_drained = out_pushed;
        end
        repeat (20) @(negedge clk);
        chk(out_pushed == 12, "R9 stops at write pointer", 32'(out_pushed), 32'd12);
        chk(!mem_req, "R9 no further requests", 32'(mem_req), 32'd0);
        for (int k = 0; k < 12; k++) begin
            logic [15:0] e;
            e = 16'h2000 + 16'((k / BLK) * 16 + (k % BLK));
            chk(out_q[k] == e, "R8 readback data", 32'(out_q[k]), 32'(e));
        end
        chk(hs_bad == 0, "R3 R8 handshake strobes", 32'(hs_bad), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule